// File: doc/BRIEF.md
# Transmit Frame Sync Generator

This block sits on the transmit side of a synchronous serial port. It drives the frame sync pin and the serial data line. Each accepted start-of-transfer strobe begins a frame. The frame has an optional sync period, then a programmable number of data words, each of programmable length. The sync waveform is chosen from six modes:

- no sync output, with the pin left as an input;
- a low pulse or a high pulse;
- a low level or a high level held for the whole data transfer;
- a level that toggles at each start.

In the pulse modes a separate sync-data word can be shifted out while the sync is active. Otherwise the data line rests at a programmed default level during that time.

All timing advances on a bit-period enable that is generated outside the block. Every configuration field is captured when a start is accepted, so software may change the inputs while a frame is in flight. The sync pin is also watched as an input. A selectable rising or falling edge on the pin, taken after a two-stage synchroniser, sets a sticky status flag that stays set until it is cleared.

Top module: `tx_fsync_gen`

## Requirements
- R1: While reset is held, and until the first start is accepted, tx_bit_o, fs_o, fs_oe_o, word_take_o and sync_flag_o are all 0.
- R2: A start is accepted only on a clock where bit_en_i and start_i are both 1 and no frame is in progress. All cfg_* inputs, sync_word_i and cfg_esel_i are captured at that moment. A start during a frame is ignored, and so are configuration changes during a frame. The first frame value is visible on the outputs after the clock edge that accepts the start.
- R3: fs_oe_o is 1 after a start with cfg_mode_i in 1..5 and 0 after a start with mode 0, 6 or 7. Modes 0, 6 and 7 have no sync period and drive fs_o to 0.
- R4: In mode 1 (low pulse) and mode 2 (high pulse), the sync lasts L+1 bit periods from the accepted start. L = {cfg_len_hi_i, cfg_len_lo_i}, limited to a maximum of 15. During the sync fs_o is 0 in mode 1 and 1 in mode 2. fs_o takes the opposite level for the data words that follow and after the frame.
- R5: In mode 3, fs_o is 0 for every data bit of the frame and goes to 1 after the last bit. In mode 4, fs_o is 1 for every data bit and goes to 0 after the last bit.
- R6: In mode 5, fs_o inverts at each accepted start and keeps that value through the frame and afterwards.
- R7: During a sync period with cfg_sden_i = 1, tx_bit_o carries bits L..0 of sync_word_i. They go out from bit L down to bit 0 when cfg_msbf_i = 1, and from bit 0 up to bit L when cfg_msbf_i = 0. With cfg_sden_i = 0, tx_bit_o holds the default level.
- R8: A frame sends cfg_dcnt_i+1 words of cfg_dlen_i+1 bits each, starting right after the sync period. There is no sync period in modes other than 1 and 2. Each word is sampled from data_word_i when it begins, and word_take_o pulses for one clock right after that sample. Bit order is bit cfg_dlen_i first when cfg_msbf_i = 1, and bit 0 first otherwise.
- R9: Outside a frame, tx_bit_o equals the captured cfg_def_i.
- R10: tx_bit_o, fs_o and fs_oe_o change only on clock edges where bit_en_i is 1.
- R11: sync_flag_o is set on the third clock edge after fs_pin_i changes, if the change is a rising edge with the captured edge select 0, or a falling edge with edge select 1. The other edge is ignored. The flag stays set until stat_clr_i. A detected edge wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en_i | input | 1 | One-clock enable marking each bit period |
| start_i | input | 1 | Start-of-transfer strobe |
| cfg_mode_i | input | 3 | Sync waveform mode (0..5; 6, 7 reserved) |
| cfg_len_hi_i | input | 4 | Upper part of the sync length |
| cfg_len_lo_i | input | 4 | Lower part of the sync length |
| cfg_sden_i | input | 1 | Shift the sync-data word during the sync |
| cfg_def_i | input | 1 | Default level of the data line |
| cfg_msbf_i | input | 1 | 1: most significant bit first |
| cfg_dlen_i | input | 5 | Bits per word minus one |
| cfg_dcnt_i | input | 4 | Words per frame minus one |
| cfg_esel_i | input | 1 | Pin edge that sets the flag: 0 rising, 1 falling |
| sync_word_i | input | 16 | Sync-data word |
| data_word_i | input | 32 | Data word source |
| fs_pin_i | input | 1 | Frame sync pin as seen at the pad |
| stat_clr_i | input | 1 | Clears the sync status flag |
| tx_bit_o | output | 1 | Serial data bit |
| fs_o | output | 1 | Frame sync output value |
| fs_oe_o | output | 1 | Frame sync pin output enable |
| word_take_o | output | 1 | Pulse after each data word is sampled |
| sync_flag_o | output | 1 | Sticky sync edge status |

## Verification
Ten table-driven frames cover every mode code and both bit orders. They include sync-data enabled and disabled, single-word and multi-word frames, a sync length that needs the upper length part and saturates, and full 16-bit sync and 32-bit data widths. Running two toggle frames back to back separates a true toggle from a fixed level, and a reserved code separates a decoded output enable from a pass-through of the mode bits. Directed runs change data_word_i at each word_take_o pulse to show per-word sampling, and hold bit_en_i low on alternate clocks to show that the outputs freeze. A start with a conflicting mode in mid-frame must leave the waveform untouched. The edge tests drive both pin directions under each edge select, and one of them raises a clear in the same cycle as a detected edge.

// File: rtl/tfs_pkg.sv
package tfs_pkg;

  typedef enum logic [2:0] {
    FS_NONE       = 3'd0,
    FS_LOW_PULSE  = 3'd1,
    FS_HIGH_PULSE = 3'd2,
    FS_LOW_LEVEL  = 3'd3,
    FS_HIGH_LEVEL = 3'd4,
    FS_TOGGLE     = 3'd5,
    FS_RSV6       = 3'd6,
    FS_RSV7       = 3'd7
  } fs_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SYNC = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  // pin is an output for the five defined waveform codes
  function automatic logic fs_drives(input fs_mode_e m);
    return (m == FS_LOW_PULSE) || (m == FS_HIGH_PULSE) || (m == FS_LOW_LEVEL) ||
           (m == FS_HIGH_LEVEL) || (m == FS_TOGGLE);
  endfunction

  function automatic logic fs_is_pulse(input fs_mode_e m);
    return (m == FS_LOW_PULSE) || (m == FS_HIGH_PULSE);
  endfunction

  // level shown while the sync (or level-mode transfer) is active
  function automatic logic fs_active_lvl(input fs_mode_e m, input logic cur);
    logic r;
    case (m)
      FS_HIGH_PULSE, FS_HIGH_LEVEL: r = 1'b1;
      FS_TOGGLE:                    r = ~cur;
      default:                      r = 1'b0;
    endcase
    return r;
  endfunction

  // level shown once the active part is over
  function automatic logic fs_rest_lvl(input fs_mode_e m, input logic cur);
    logic r;
    case (m)
      FS_LOW_PULSE, FS_LOW_LEVEL: r = 1'b1;
      FS_TOGGLE:                  r = cur;
      default:                    r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tfs_edge_flag.sv
module tfs_edge_flag #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic edge_sel_i,
  input  logic clr_i,
  output logic hit_o,
  output logic flag_o
);

  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q, chain_d;
  logic               flag_q, flag_d;
  logic               synced, prev;

  assign synced = chain_q[SYNC_STAGES-1];
  assign prev   = chain_q[SYNC_STAGES];

  always_comb begin
    chain_d = {chain_q[CHAIN_W-2:0], pin_i};
    hit_o   = edge_sel_i ? (prev & ~synced) : (synced & ~prev);
    if (hit_o) begin
      flag_d = 1'b1;
    end else if (clr_i) begin
      flag_d = 1'b0;
    end else begin
      flag_d = flag_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      flag_q  <= flag_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/tfs_bit_pick.sv
module tfs_bit_pick #(
  parameter int W     = 16,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     word_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [IDX_W-1:0] last_i,
  input  logic             msb_first_i,
  output logic             bit_o
);

  // idx counts down from last to zero; the order picks which end leads
  logic [IDX_W-1:0] rev_idx;

  always_comb begin
    rev_idx = last_i - idx_i;
    bit_o   = msb_first_i ? word_i[idx_i] : word_i[rev_idx];
  end

endmodule

// File: rtl/tfs_frame_ctl.sv
module tfs_frame_ctl
  import tfs_pkg::*;
#(
  parameter int SYNC_W   = 16,
  parameter int DATA_W   = 32,
  parameter int LEN_HI_W = 4,
  parameter int LEN_LO_W = 4,
  parameter int DCNT_W   = 4,
  parameter int SIDX_W   = $clog2(SYNC_W),
  parameter int DIDX_W   = $clog2(DATA_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_en_i,
  input  logic                start_i,
  input  logic [2:0]          cfg_mode_i,
  input  logic [LEN_HI_W-1:0] cfg_len_hi_i,
  input  logic [LEN_LO_W-1:0] cfg_len_lo_i,
  input  logic                cfg_sden_i,
  input  logic                cfg_def_i,
  input  logic                cfg_msbf_i,
  input  logic [DIDX_W-1:0]   cfg_dlen_i,
  input  logic [DCNT_W-1:0]   cfg_dcnt_i,
  input  logic                cfg_esel_i,
  input  logic [SYNC_W-1:0]   sync_word_i,
  input  logic [DATA_W-1:0]   data_word_i,
  output logic                tx_bit_o,
  output logic                fs_o,
  output logic                word_take_o,
  output logic                busy_o,
  output fs_mode_e            mode_o,
  output logic                def_o,
  output logic                esel_o
);

  localparam int LEN_W = LEN_HI_W + LEN_LO_W;
  localparam logic [LEN_W-1:0]  LEN_CAP  = LEN_W'(SYNC_W - 1);
  localparam logic [SIDX_W-1:0] SIDX_MAX = SIDX_W'(SYNC_W - 1);

  phase_e              phase_q, phase_d;
  fs_mode_e            mode_q, mode_d, mode_new;
  logic                sden_q, sden_d;
  logic                def_q, def_d;
  logic                msbf_q, msbf_d;
  logic                esel_q, esel_d;
  logic [SIDX_W-1:0]   eff_q, eff_d, eff_new;
  logic [DIDX_W-1:0]   dlen_q, dlen_d;
  logic [SYNC_W-1:0]   sword_q, sword_d;
  logic [DATA_W-1:0]   dword_q, dword_d;
  logic [SIDX_W-1:0]   sidx_q, sidx_d;
  logic [DIDX_W-1:0]   didx_q, didx_d;
  logic [DCNT_W-1:0]   wcnt_q, wcnt_d;
  logic                fs_q, fs_d;
  logic                tx_q, tx_d;
  logic                take_q, take_d;
  logic                load_word;
  logic [LEN_W-1:0]    len_full;
  logic                sync_bit, data_bit;

  assign mode_new = fs_mode_e'(cfg_mode_i);
  assign len_full = {cfg_len_hi_i, cfg_len_lo_i};
  assign eff_new  = (len_full > LEN_CAP) ? SIDX_MAX : len_full[SIDX_W-1:0];

  // next-state logic, evaluated for the next bit-enable edge
  always_comb begin
    phase_d   = phase_q;
    mode_d    = mode_q;
    sden_d    = sden_q;
    def_d     = def_q;
    msbf_d    = msbf_q;
    esel_d    = esel_q;
    eff_d     = eff_q;
    dlen_d    = dlen_q;
    sword_d   = sword_q;
    dword_d   = dword_q;
    sidx_d    = sidx_q;
    didx_d    = didx_q;
    wcnt_d    = wcnt_q;
    fs_d      = fs_q;
    take_d    = 1'b0;
    load_word = 1'b0;

    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          mode_d  = mode_new;
          sden_d  = cfg_sden_i;
          def_d   = cfg_def_i;
          msbf_d  = cfg_msbf_i;
          esel_d  = cfg_esel_i;
          eff_d   = eff_new;
          dlen_d  = cfg_dlen_i;
          sword_d = sync_word_i;
          wcnt_d  = cfg_dcnt_i;
          fs_d    = fs_active_lvl(mode_new, fs_q);
          if (fs_is_pulse(mode_new)) begin
            phase_d = PH_SYNC;
            sidx_d  = eff_new;
          end else begin
            phase_d   = PH_DATA;
            load_word = 1'b1;
          end
        end
      end
      PH_SYNC: begin
        if (sidx_q == '0) begin
          phase_d   = PH_DATA;
          load_word = 1'b1;
          fs_d      = fs_rest_lvl(mode_q, fs_q);
        end else begin
          sidx_d = sidx_q - 1'b1;
        end
      end
      PH_DATA: begin
        if (didx_q == '0) begin
          if (wcnt_q == '0) begin
            phase_d = PH_IDLE;
            fs_d    = fs_rest_lvl(mode_q, fs_q);
          end else begin
            wcnt_d    = wcnt_q - 1'b1;
            load_word = 1'b1;
          end
        end else begin
          didx_d = didx_q - 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase

    if (load_word) begin
      dword_d = data_word_i;
      didx_d  = dlen_d;
      take_d  = 1'b1;
    end
  end

  tfs_bit_pick #(.W(SYNC_W), .IDX_W(SIDX_W)) u_sync_pick (
    .word_i      (sword_d),
    .idx_i       (sidx_d),
    .last_i      (eff_d),
    .msb_first_i (msbf_d),
    .bit_o       (sync_bit)
  );

  tfs_bit_pick #(.W(DATA_W), .IDX_W(DIDX_W)) u_data_pick (
    .word_i      (dword_d),
    .idx_i       (didx_d),
    .last_i      (dlen_d),
    .msb_first_i (msbf_d),
    .bit_o       (data_bit)
  );

  always_comb begin
    unique case (phase_d)
      PH_SYNC: tx_d = sden_d ? sync_bit : def_d;
      PH_DATA: tx_d = data_bit;
      default: tx_d = def_d;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      mode_q  <= FS_NONE;
      sden_q  <= 1'b0;
      def_q   <= 1'b0;
      msbf_q  <= 1'b0;
      esel_q  <= 1'b0;
      eff_q   <= '0;
      dlen_q  <= '0;
      sword_q <= '0;
      dword_q <= '0;
      sidx_q  <= '0;
      didx_q  <= '0;
      wcnt_q  <= '0;
      fs_q    <= 1'b0;
      tx_q    <= 1'b0;
      take_q  <= 1'b0;
    end else begin
      take_q <= bit_en_i & take_d;
      if (bit_en_i) begin
        phase_q <= phase_d;
        mode_q  <= mode_d;
        sden_q  <= sden_d;
        def_q   <= def_d;
        msbf_q  <= msbf_d;
        esel_q  <= esel_d;
        eff_q   <= eff_d;
        dlen_q  <= dlen_d;
        sword_q <= sword_d;
        dword_q <= dword_d;
        sidx_q  <= sidx_d;
        didx_q  <= didx_d;
        wcnt_q  <= wcnt_d;
        fs_q    <= fs_d;
        tx_q    <= tx_d;
      end
    end
  end

  assign tx_bit_o    = tx_q;
  assign fs_o        = fs_q;
  assign word_take_o = take_q;
  assign busy_o      = (phase_q != PH_IDLE);
  assign mode_o      = mode_q;
  assign def_o       = def_q;
  assign esel_o      = esel_q;

endmodule

// File: rtl/tx_fsync_gen.sv
module tx_fsync_gen
  import tfs_pkg::*;
#(
  parameter int SYNC_W      = 16,
  parameter int DATA_W      = 32,
  parameter int LEN_HI_W    = 4,
  parameter int LEN_LO_W    = 4,
  parameter int DCNT_W      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int DIDX_W     = $clog2(DATA_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_en_i,
  input  logic                start_i,
  input  logic [2:0]          cfg_mode_i,
  input  logic [LEN_HI_W-1:0] cfg_len_hi_i,
  input  logic [LEN_LO_W-1:0] cfg_len_lo_i,
  input  logic                cfg_sden_i,
  input  logic                cfg_def_i,
  input  logic                cfg_msbf_i,
  input  logic [DIDX_W-1:0]   cfg_dlen_i,
  input  logic [DCNT_W-1:0]   cfg_dcnt_i,
  input  logic                cfg_esel_i,
  input  logic [SYNC_W-1:0]   sync_word_i,
  input  logic [DATA_W-1:0]   data_word_i,
  input  logic                fs_pin_i,
  input  logic                stat_clr_i,
  output logic                tx_bit_o,
  output logic                fs_o,
  output logic                fs_oe_o,
  output logic                word_take_o,
  output logic                sync_flag_o
);

  fs_mode_e mode_q;
  logic     def_q;
  logic     esel_q;
  logic     busy;
  logic     edge_hit;

  tfs_frame_ctl #(
    .SYNC_W   (SYNC_W),
    .DATA_W   (DATA_W),
    .LEN_HI_W (LEN_HI_W),
    .LEN_LO_W (LEN_LO_W),
    .DCNT_W   (DCNT_W)
  ) u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_en_i     (bit_en_i),
    .start_i      (start_i),
    .cfg_mode_i   (cfg_mode_i),
    .cfg_len_hi_i (cfg_len_hi_i),
    .cfg_len_lo_i (cfg_len_lo_i),
    .cfg_sden_i   (cfg_sden_i),
    .cfg_def_i    (cfg_def_i),
    .cfg_msbf_i   (cfg_msbf_i),
    .cfg_dlen_i   (cfg_dlen_i),
    .cfg_dcnt_i   (cfg_dcnt_i),
    .cfg_esel_i   (cfg_esel_i),
    .sync_word_i  (sync_word_i),
    .data_word_i  (data_word_i),
    .tx_bit_o     (tx_bit_o),
    .fs_o         (fs_o),
    .word_take_o  (word_take_o),
    .busy_o       (busy),
    .mode_o       (mode_q),
    .def_o        (def_q),
    .esel_o       (esel_q)
  );

  tfs_edge_flag #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (fs_pin_i),
    .edge_sel_i (esel_q),
    .clr_i      (stat_clr_i),
    .hit_o      (edge_hit),
    .flag_o     (sync_flag_o)
  );

  assign fs_oe_o = fs_drives(mode_q);

endmodule

// File: rtl/tfs_chk.sv
module tfs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en_i,
  input logic       stat_clr_i,
  input logic       tx_bit_o,
  input logic       fs_o,
  input logic       fs_oe_o,
  input logic       sync_flag_o,
  input logic       busy,
  input logic [2:0] mode_q,
  input logic       def_q,
  input logic       edge_hit
);

  // R10
  hold_no_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en_i |=> ($stable(tx_bit_o) && $stable(fs_o) && $stable(fs_oe_o)));

  // R2
  busy_oe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(fs_oe_o));

  // R5
  high_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q == 3'd4) |-> fs_o);

  // R5
  low_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q == 3'd3) |-> !fs_o);

  // R9
  idle_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (tx_bit_o == def_q));

  // R11
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> sync_flag_o);

  // R11
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr_i && !edge_hit) |=> !sync_flag_o);

endmodule

bind tx_fsync_gen tfs_chk u_tfs_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bit_en_i    (bit_en_i),
  .stat_clr_i  (stat_clr_i),
  .tx_bit_o    (tx_bit_o),
  .fs_o        (fs_o),
  .fs_oe_o     (fs_oe_o),
  .sync_flag_o (sync_flag_o),
  .busy        (busy),
  .mode_q      (mode_q),
  .def_q       (def_q),
  .edge_hit    (edge_hit)
);

// File: tb/tx_fsync_gen_bench.sv
module tx_fsync_gen_bench;

  typedef struct packed {
    logic [2:0]  mode;
    logic [3:0]  hi;
    logic [3:0]  lo;
    logic        sden;
    logic        def;
    logic        msbf;
    logic [4:0]  dlen;
    logic [3:0]  dcnt;
    logic        esel;
    logic [15:0] sw;
    logic [31:0] dw;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{3'd1, 4'd0, 4'd3,  1'b1, 1'b0, 1'b1, 5'd7,  4'd0, 1'b0, 16'h000A, 32'h000000A5},
    '{3'd2, 4'd0, 4'd2,  1'b0, 1'b1, 1'b0, 5'd3,  4'd1, 1'b0, 16'hFFFF, 32'h00000006},
    '{3'd3, 4'd0, 4'd0,  1'b0, 1'b0, 1'b1, 5'd4,  4'd1, 1'b0, 16'h0000, 32'h00000013},
    '{3'd4, 4'd0, 4'd0,  1'b0, 1'b1, 1'b0, 5'd2,  4'd2, 1'b0, 16'h0000, 32'h00000005},
    '{3'd5, 4'd0, 4'd0,  1'b0, 1'b0, 1'b1, 5'd1,  4'd0, 1'b0, 16'h0000, 32'h00000002},
    '{3'd5, 4'd0, 4'd0,  1'b0, 1'b1, 1'b0, 5'd1,  4'd0, 1'b0, 16'h0000, 32'h00000001},
    '{3'd0, 4'd0, 4'd5,  1'b1, 1'b0, 1'b1, 5'd3,  4'd0, 1'b0, 16'h0000, 32'h00000009},
    '{3'd2, 4'd1, 4'd0,  1'b1, 1'b0, 1'b0, 5'd0,  4'd0, 1'b0, 16'h8001, 32'h00000001},
    '{3'd6, 4'd0, 4'd0,  1'b0, 1'b1, 1'b0, 5'd0,  4'd0, 1'b0, 16'h0000, 32'h00000000},
    '{3'd1, 4'd0, 4'd15, 1'b1, 1'b0, 1'b1, 5'd31, 4'd0, 1'b0, 16'hC3A5, 32'h80000001}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bit_en_i;
  logic        start_i;
  logic [2:0]  cfg_mode_i;
  logic [3:0]  cfg_len_hi_i;
  logic [3:0]  cfg_len_lo_i;
  logic        cfg_sden_i;
  logic        cfg_def_i;
  logic        cfg_msbf_i;
  logic [4:0]  cfg_dlen_i;
  logic [3:0]  cfg_dcnt_i;
  logic        cfg_esel_i;
  logic [15:0] sync_word_i;
  logic [31:0] data_word_i;
  logic        fs_pin_i;
  logic        stat_clr_i;
  logic        tx_bit_o;
  logic        fs_o;
  logic        fs_oe_o;
  logic        word_take_o;
  logic        sync_flag_o;

  int   checks = 0;
  int   errs   = 0;
  logic done   = 1'b0;
  logic model_fs = 1'b0;

  always #5 clk = ~clk;

  tx_fsync_gen u_tx_fsync_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_en_i     (bit_en_i),
    .start_i      (start_i),
    .cfg_mode_i   (cfg_mode_i),
    .cfg_len_hi_i (cfg_len_hi_i),
    .cfg_len_lo_i (cfg_len_lo_i),
    .cfg_sden_i   (cfg_sden_i),
    .cfg_def_i    (cfg_def_i),
    .cfg_msbf_i   (cfg_msbf_i),
    .cfg_dlen_i   (cfg_dlen_i),
    .cfg_dcnt_i   (cfg_dcnt_i),
    .cfg_esel_i   (cfg_esel_i),
    .sync_word_i  (sync_word_i),
    .data_word_i  (data_word_i),
    .fs_pin_i     (fs_pin_i),
    .stat_clr_i   (stat_clr_i),
    .tx_bit_o     (tx_bit_o),
    .fs_o         (fs_o),
    .fs_oe_o      (fs_oe_o),
    .word_take_o  (word_take_o),
    .sync_flag_o  (sync_flag_o)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic apply_cfg(input vec_t v);
    cfg_mode_i   = v.mode;
    cfg_len_hi_i = v.hi;
    cfg_len_lo_i = v.lo;
    cfg_sden_i   = v.sden;
    cfg_def_i    = v.def;
    cfg_msbf_i   = v.msbf;
    cfg_dlen_i   = v.dlen;
    cfg_dcnt_i   = v.dcnt;
    cfg_esel_i   = v.esel;
    sync_word_i  = v.sw;
    data_word_i  = v.dw;
  endtask

  // phase: 0 sync, 1 data, 2 after the frame
  function automatic logic exp_fs(input vec_t v, input int ph, input logic prev);
    case (v.mode)
      3'd1:    return (ph == 0) ? 1'b0 : 1'b1;
      3'd2:    return (ph == 0) ? 1'b1 : 1'b0;
      3'd3:    return (ph == 1) ? 1'b0 : 1'b1;
      3'd4:    return (ph == 1) ? 1'b1 : 1'b0;
      3'd5:    return ~prev;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string fs_tag(input logic [2:0] m);
    case (m)
      3'd1, 3'd2: return "R4";
      3'd3, 3'd4: return "R5";
      3'd5:       return "R6";
      default:    return "R3";
    endcase
  endfunction

  task automatic run_frame(input vec_t v);
    int   eff, ns, bits, nd, total;
    logic etx, efs;
    int   ph;
    eff   = ({v.hi, v.lo} > 8'd15) ? 15 : int'({v.hi, v.lo});
    ns    = (v.mode == 3'd1 || v.mode == 3'd2) ? eff + 1 : 0;
    bits  = int'(v.dlen) + 1;
    nd    = (int'(v.dcnt) + 1) * bits;
    total = ns + nd;
    @(negedge clk);
    apply_cfg(v);
    bit_en_i = 1'b1;
    start_i  = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int p = 0; p <= total; p++) begin
      if (p > 0) @(negedge clk);
      if (p < ns) begin
        ph  = 0;
        etx = v.sden ? (v.msbf ? v.sw[eff - p] : v.sw[p]) : v.def;
        check("R7", "sync bit", 32'(tx_bit_o), 32'(etx));
      end else if (p < total) begin
        ph  = 1;
        etx = v.msbf ? v.dw[v.dlen - ((p - ns) % bits)] : v.dw[(p - ns) % bits];
        check("R8", "data bit", 32'(tx_bit_o), 32'(etx));
      end else begin
        ph  = 2;
        check("R9", "idle bit", 32'(tx_bit_o), 32'(v.def));
      end
      efs = exp_fs(v, ph, model_fs);
      check(fs_tag(v.mode), "sync level", 32'(fs_o), 32'(efs));
      if (p == 0) begin
        check("R3", "output enable", 32'(fs_oe_o),
              32'(v.mode >= 3'd1 && v.mode <= 3'd5));
      end
    end
    model_fs = exp_fs(v, 2, model_fs);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    vec_t v;
    rst_n      = 1'b0;
    bit_en_i   = 1'b0;
    start_i    = 1'b0;
    fs_pin_i   = 1'b0;
    stat_clr_i = 1'b0;
    apply_cfg('0);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "tx", 32'(tx_bit_o), 32'd0);
    check("R1", "fs", 32'(fs_o), 32'd0);
    check("R1", "oe", 32'(fs_oe_o), 32'd0);
    check("R1", "flag", 32'(sync_flag_o), 32'd0);
    check("R1", "take", 32'(word_take_o), 32'd0);
    rst_n = 1'b1;
    bit_en_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "tx after release", 32'(tx_bit_o), 32'd0);
    check("R1", "oe after release", 32'(fs_oe_o), 32'd0);

    // table-driven frames
    for (int i = 0; i < NVEC; i++) begin
      run_frame(VECS[i]);
    end

    // R8: per-word sampling with word_take_o
    begin
      logic [3:0] words [3];
      logic [3:0] cur;
      int         widx;
      words[0] = 4'h9;
      words[1] = 4'h3;
      words[2] = 4'hC;
      widx = 0;
      v = '{3'd0, 4'd0, 4'd0, 1'b0, 1'b1, 1'b0, 5'd3, 4'd2, 1'b0, 16'h0, 32'h9};
      @(negedge clk);
      apply_cfg(v);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int p = 0; p <= 12; p++) begin
        if (p > 0) @(negedge clk);
        if (p < 12) begin
          cur = words[p / 4];
          check("R8", "per-word bit", 32'(tx_bit_o), 32'(cur[p % 4]));
          check("R8", "take pulse", 32'(word_take_o), 32'(p % 4 == 0));
        end else begin
          check("R9", "idle after words", 32'(tx_bit_o), 32'd1);
          check("R8", "no take idle", 32'(word_take_o), 32'd0);
        end
        if (word_take_o && widx < 2) begin
          widx++;
          data_word_i = 32'(words[widx]);
        end
      end
      model_fs = 1'b0;
    end

    // R10: bit enable on alternate clocks
    begin
      logic [3:0] pat;
      int         pos;
      pat = 4'b1010;
      v = '{3'd4, 4'd0, 4'd0, 1'b0, 1'b0, 1'b1, 5'd3, 4'd0, 1'b0, 16'h0, 32'hA};
      @(negedge clk);
      apply_cfg(v);
      bit_en_i = 1'b1;
      start_i  = 1'b1;
      for (int k = 1; k <= 9; k++) begin
        @(negedge clk);
        start_i = 1'b0;
        pos = (k - 1) / 2;
        if (pos < 4) begin
          check("R10", "held data bit", 32'(tx_bit_o), 32'(pat[3 - pos]));
          check("R10", "held level", 32'(fs_o), 32'd1);
        end else begin
          check("R10", "held idle bit", 32'(tx_bit_o), 32'd0);
          check("R10", "held idle level", 32'(fs_o), 32'd0);
        end
        bit_en_i = (k % 2 == 0);
      end
      bit_en_i = 1'b1;
      model_fs = 1'b0;
    end

    // R2: start and config changes during a frame are ignored
    begin
      logic exp_tx [5];
      logic exp_f  [5];
      exp_tx = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
      exp_f  = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
      v = '{3'd2, 4'd0, 4'd1, 1'b0, 1'b0, 1'b1, 5'd1, 4'd0, 1'b0, 16'h0, 32'h1};
      @(negedge clk);
      apply_cfg(v);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int p = 0; p <= 4; p++) begin
        if (p > 0) @(negedge clk);
        start_i = 1'b0;
        check("R2", "tx under restart", 32'(tx_bit_o), 32'(exp_tx[p]));
        check("R2", "fs under restart", 32'(fs_o), 32'(exp_f[p]));
        if (p == 1) begin
          cfg_mode_i = 3'd4;
          cfg_dlen_i = 5'd7;
          start_i    = 1'b1;
        end
      end
      check("R2", "oe kept", 32'(fs_oe_o), 32'd1);
      repeat (3) @(negedge clk);
      check("R2", "no late restart", 32'(fs_o), 32'd0);
      model_fs = 1'b0;
    end

    // R11: edge detection
    v = '{3'd0, 4'd0, 4'd0, 1'b0, 1'b0, 1'b0, 5'd0, 4'd0, 1'b0, 16'h0, 32'h0};
    run_frame(v);
    @(negedge clk);
    fs_pin_i = 1'b1;
    repeat (2) @(negedge clk);
    check("R11", "rise not yet", 32'(sync_flag_o), 32'd0);
    @(negedge clk);
    check("R11", "rise sets", 32'(sync_flag_o), 32'd1);
    fs_pin_i = 1'b0;
    repeat (5) @(negedge clk);
    check("R11", "sticky", 32'(sync_flag_o), 32'd1);
    stat_clr_i = 1'b1;
    @(negedge clk);
    stat_clr_i = 1'b0;
    check("R11", "cleared", 32'(sync_flag_o), 32'd0);
    fs_pin_i = 1'b1;
    repeat (5) @(negedge clk);
    stat_clr_i = 1'b1;
    @(negedge clk);
    stat_clr_i = 1'b0;
    fs_pin_i = 1'b0;
    repeat (5) @(negedge clk);
    check("R11", "fall ignored sel0", 32'(sync_flag_o), 32'd0);
    v.esel = 1'b1;
    run_frame(v);
    @(negedge clk);
    fs_pin_i = 1'b1;
    repeat (5) @(negedge clk);
    check("R11", "rise ignored sel1", 32'(sync_flag_o), 32'd0);
    fs_pin_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R11", "fall not yet", 32'(sync_flag_o), 32'd0);
    @(negedge clk);
    check("R11", "fall sets", 32'(sync_flag_o), 32'd1);
    stat_clr_i = 1'b1;
    @(negedge clk);
    stat_clr_i = 1'b0;
    check("R11", "cleared again", 32'(sync_flag_o), 32'd0);
    fs_pin_i = 1'b1;
    repeat (5) @(negedge clk);
    fs_pin_i = 1'b0;
    repeat (2) @(negedge clk);
    stat_clr_i = 1'b1;
    @(negedge clk);
    stat_clr_i = 1'b0;
    check("R11", "edge wins over clear", 32'(sync_flag_o), 32'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule